// File: doc/BRIEF.md
# Power-On and External Reset Conditioner

This block generates the one active-high system reset for a single clock domain. The reset has two sources. The first is a power-on reset: a short shift register that comes out of configuration holding all ones, so reset is active before any clock edge and clears by itself. The second is an active-low reset pin driven by an external controller. When that pin idles high, whether driven or pulled up, the design runs normally.

The raw pin is never connected straight to the reset chain. It first passes through a two-flop synchronizer clocked by the system clock, and both of those flops also start at one. The synchronized level then sets the reset chain asynchronously. Release always happens on the clock: the chain shifts zeros toward its top bit, and the top bit is the system reset. The whole chip can instantiate the block once and distribute its output.

Top module: `rst_cond`

## Requirements
- R1: Starting from configuration with the pin held high, the output reads 1 before the first rising clock edge and after the first and second edges, and reads 0 from the third edge onward.
- R2: While the synchronized external request is low, the output stays at 1 for any length of time.
- R3: A low pin level seen at rising edge k reaches the synchronized request at edge k+1, which drives the output to 1. At edge k itself the output does not change.
- R4: A pin held steadily high never asserts the output after the power-on release. A low glitch on the pin that contains no rising clock edge has no effect on the output.
- R5: The synchronized request at each rising edge equals the pin level sampled two rising edges earlier. The pin passes through exactly two flip-flops.
- R6: After the synchronized request returns high, the output stays 1 through the next two rising edges and drops to 0 on the third. It does not glitch in between.
- R7: A new request that arrives while a release is under way sets the chain back to all ones, and the full three-edge release starts again once the request clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock of the reset domain |
| rst_ni | input | 1 | Raw external reset pin, active low, asynchronous to clk_i |
| rst_o | output | 1 | Conditioned system reset, active high |

## Verification
The bench targets the exact cycle of each assertion and release. An extra synchronizer stage, or a missing one, shows up as the output moving one edge early or late. A chain that is too short or too long releases at the wrong edge after power-on or after a pin pulse. The bench sends a low glitch that falls entirely between two edges; a design that wired the pin asynchronously into the chain would reset on it. It also sends a sub-cycle pulse that straddles an edge, which must be caught. A request that lands in the middle of a release checks that the release count restarts from the beginning rather than continuing from where it was.

// File: rtl/rst_cond_pkg.sv
`timescale 1ns/1ps
package rst_cond_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned CHAIN_DEPTH_DEF = 3;
endpackage

// File: rtl/rst_cond_sync.sv
`timescale 1ns/1ps
module rst_cond_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic req_no
);
  // Power-up value 1: no request pending, so an idle-high pin adds no extra reset.
  logic [STAGES-1:0] ff_q = '1;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) ff_q <= rst_ni;
    end else begin : g_multi
      always_ff @(posedge clk_i) ff_q <= {ff_q[STAGES-2:0], rst_ni};
    end
  endgenerate

  assign req_no = ff_q[STAGES-1];

  // Checker: past-valid counter for the latency check.
  logic [1:0] seen_q = '0;
  always_ff @(posedge clk_i) if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_latency_R5: assert property (@(posedge clk_i)
        (seen_q == 2'd2) |-> (req_no == $past(rst_ni, 2)));
    end
  endgenerate
endmodule

// File: rtl/rst_cond_chain.sv
`timescale 1ns/1ps
module rst_cond_chain #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic req_ni,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] REL_MAX = CW'(DEPTH);

  // Power-up value all ones: reset is active from configuration onward.
  logic [DEPTH-1:0] chain_q = '1;

  always_ff @(posedge clk_i or negedge req_ni) begin
    if (!req_ni) chain_q <= '1;
    else         chain_q <= {chain_q[DEPTH-2:0], 1'b0};
  end

  assign rst_o = chain_q[DEPTH-1];

  // Checker: edges counted since the request was last released.
  logic [CW-1:0] rel_q = '0;
  logic          seen_q = 1'b0;
  always_ff @(posedge clk_i or negedge req_ni) begin
    if (!req_ni)              rel_q <= '0;
    else if (rel_q != REL_MAX) rel_q <= rel_q + 1'b1;
  end
  always_ff @(posedge clk_i) seen_q <= 1'b1;

  assert_held_by_req_R2: assert property (@(posedge clk_i)
    !req_ni |-> rst_o);

  assert_release_hold_R6: assert property (@(posedge clk_i) disable iff (!req_ni)
    (rel_q < REL_MAX) |-> rst_o);

  assert_release_done_R1: assert property (@(posedge clk_i) disable iff (!req_ni)
    (rel_q == REL_MAX) |-> !rst_o);

  assert_rise_needs_req_R4: assert property (@(posedge clk_i)
    (seen_q && $rose(rst_o)) |-> !req_ni);
endmodule

// File: rtl/rst_cond.sv
`timescale 1ns/1ps
module rst_cond
  import rst_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned CHAIN_DEPTH = CHAIN_DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_o
);
  logic req_n;

  rst_cond_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_no (req_n)
  );

  rst_cond_chain #(.DEPTH(CHAIN_DEPTH)) chain_i (
    .clk_i  (clk_i),
    .req_ni (req_n),
    .rst_o  (rst_o)
  );
endmodule

// File: tb/rst_cond_tb_top.sv
`timescale 1ns/1ps
module rst_cond_tb_top;
  logic clk = 1'b0;
  logic pin_n = 1'b1;
  logic rst;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cond dut_i (.clk_i(clk), .rst_ni(pin_n), .rst_o(rst));

  // {pin level driven before the edge, expected rst_o after the edge}
  localparam int NV = 36;
  localparam logic [1:0] VEC [NV] = '{
    2'b11, 2'b11, 2'b10, 2'b10,
    2'b00, 2'b01, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10, 2'b10,
    2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10,
    2'b00, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10, 2'b10,
    2'b00, 2'b01, 2'b01, 2'b01, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10
  };

  function automatic string vec_tag(int i);
    if (i < 4)  return "R1";
    if (i < 12) return "R3";
    if (i < 18) return "R6";
    if (i < 27) return "R7";
    return "R2";
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: rst_o got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1;
    check("R1", rst, 1'b1, "before first edge");

    for (int i = 0; i < NV; i++) begin
      pin_n = VEC[i][1];
      step();
      check(vec_tag(i), rst, VEC[i][0], $sformatf("table step %0d", i));
    end

    // R4: low glitch with no rising edge inside it is ignored
    #0.5 pin_n = 1'b0;
    #1.0 pin_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R4", rst, 1'b0, $sformatf("glitch between edges, cycle %0d", k));
    end

    // R3/R6: sub-cycle pulse straddling a rising edge is captured
    #2.0 pin_n = 1'b0;
    #1.0 pin_n = 1'b1;
    @(negedge clk);
    check("R3", rst, 1'b0, "straddle pulse, first edge");
    for (int k = 0; k < 4; k++) begin
      step();
      check(k == 0 ? "R3" : "R6", rst, 1'b1, $sformatf("straddle pulse hold %0d", k));
    end
    step();
    check("R6", rst, 1'b0, "straddle pulse release");

    // R4: long steady-high pin keeps reset off; R5 latency verified by table timing
    for (int k = 0; k < 20; k++) begin
      step();
      check("R4", rst, 1'b0, $sformatf("steady high %0d", k));
    end

    // R5: low pin seen after exactly two flop stages
    pin_n = 1'b0;
    step();
    check("R5", rst, 1'b0, "one stage only");
    step();
    check("R5", rst, 1'b1, "second stage");
    pin_n = 1'b1;
    for (int k = 0; k < 6; k++) step();
    check("R5", rst, 1'b0, "settled after pulse");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule